// File: doc/BRIEF.md
# I2C Slave Receiver with Ninth-Clock Hold

This block is the receive half of an I2C target. It watches the open-drain SCL and SDA lines through synchronizers and detects START and STOP conditions. It shifts in the first byte after a START and compares its upper seven bits with a 7-bit own address supplied by local logic. When the address matches and the direction bit asks for a write, the block pulls SDA low during the ninth clock, so the address is acknowledged in hardware.

At the falling edge of every ninth clock in an addressed transfer, the block holds SCL low and emits a one-cycle interrupt. It keeps SCL low until local logic pulses a wait-release strobe. This gives the local side all the time it needs to look at the address or to read the received byte before the controller may continue. Data bytes are acknowledged automatically while the ack-enable input is high. When the address does not match, the block stays off the bus until the next START.

The bus lines are modelled as wired-AND. The outputs `scl_oe` and `sda_oe` mean "pull this line low" and are meant to drive open-drain pads.

Top module: `i2c_wait_slave`

## Requirements
- R1: SCL and SDA each pass through a two-stage synchronizer, and all edges are detected on the synchronized copies. When the controller pulls SCL low at the end of a ninth clock, `scl_oe` is still low two clock cycles later and is high three clock cycles later. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.
- R2: The first byte after a START is taken MSB first, on SCL rising edges. Its bits 7..1 hold the address and bit 0 is the direction, with 0 meaning write. When bits 7..1 equal `own_addr` and bit 0 is 0, the block pulls SDA low during the ninth clock.
- R3: After a matching address, the block holds SCL low from the falling edge of the ninth clock. In that same cycle it raises `irq` for exactly one cycle, with `irq_addr`=1 and `addr_match`=1.
- R4: Once held, SCL stays held for as long as `wait_rel` is low. The cycle after a `wait_rel` pulse, `scl_oe` is 0.
- R5: After an address match, each data byte is shifted in MSB first. It is visible on `rx_data` from the eighth SCL rising edge of that byte.
- R6: The ACK for a data byte is decided by `ack_en` as sampled at the eighth bit. When `ack_en` is 1 the block pulls SDA low in the ninth clock. When it is 0 the block leaves SDA released, which is a NACK.
- R7: After every data byte, whether or not it was acknowledged, the block holds SCL low from the ninth falling edge. In that cycle it pulses `irq` with `irq_addr`=0.
- R8: On an address mismatch, or a matching address with direction bit 1, the block never drives SDA, never holds SCL and raises no `irq`. Any further bytes are ignored until the next START, and `rx_data` stays unchanged.
- R9: A STOP clears `addr_match`. A repeated START restarts address reception, so a matching address after a mismatched one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| own_addr | input | ADDR_W | Own 7-bit address |
| ack_en | input | 1 | Acknowledge received data bytes |
| wait_rel | input | 1 | One-cycle strobe that releases a held SCL |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| rx_data | output | DATA_W | Last received data byte |
| irq | output | 1 | One-cycle interrupt at a ninth falling edge |
| irq_addr | output | 1 | 1 = last interrupt was address match, 0 = end of data byte |
| addr_match | output | 1 | Block is addressed in the current transfer |

## Verification
The bench builds the block with its defaults: DATA_W of 8, which gives a 7-bit address, and two synchronizer stages. That keeps the address space small enough to sweep all 128 addresses against a fixed own address. Every mismatch path and the single match are therefore covered, and several own-address values are tried at the edges of the range. With the two-stage synchronizer, the hold latency after the controller's ninth falling edge is a fixed three cycles, so the bench checks it exactly. Sixteen data bytes, computed arithmetically with `ack_en` alternating, cover both acknowledge outcomes, the end-of-transfer interrupt and a long hold.

// File: rtl/i2c_ws_pkg.sv
// Shared types for the I2C slave receiver with ninth-clock hold.
// Assumes: nothing beyond standard SystemVerilog.
package i2c_ws_pkg;

    // Transfer phase of the receiver
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no START seen, or after STOP
        PH_ADDR = 2'd1,   // receiving / acknowledging the address byte
        PH_DATA = 2'd2,   // addressed, receiving data bytes
        PH_SKIP = 2'd3    // not addressed, silent until next START
    } phase_t;

endpackage

// File: rtl/i2c_ws_sync.sv
// Synchronizer and edge detector for one asynchronous bus line.
// Assumes: the line idles high, so the stages reset to 1.
module i2c_ws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] pipe;
    logic              prev;

    // Shift the raw level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    // Keep the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= pipe[STAGES-1];
    end

    assign dout = pipe[STAGES-1];
    assign rise = dout & ~prev;
    assign fall = ~dout & prev;

endmodule

// File: rtl/i2c_ws_shift.sv
// Bit counter and input shift register for one I2C byte plus its ACK slot.
// Assumes: clr wins over everything; the counter wraps on the ninth falling edge.
module i2c_ws_shift #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    output logic [CNT_W-1:0]  cnt,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] WRAP     = CNT_W'(DATA_W + 1);

    logic [DATA_W-1:0] shreg;

    // Count SCL rising edges of a byte and its ACK bit, wrap after the ninth clock
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (clr)                         cnt <= '0;
        else if (scl_fall && cnt == WRAP)     cnt <= '0;
        else if (scl_rise && cnt <= ACK_SLOT) cnt <= cnt + 1'b1;
    end

    // Shift data bits in, MSB first, on rising edges of the data bits
    always_ff @(posedge clk) begin
        if (!rst_n)                           shreg <= '0;
        else if (scl_rise && cnt < ACK_SLOT)  shreg <= {shreg[DATA_W-2:0], sda};
    end

    assign byte_done = scl_rise && (cnt == LAST_BIT);
    assign byte_val  = {shreg[DATA_W-2:0], sda};

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= WRAP);                                                       // R5
    AST_BYTE_AT_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !clr |=> cnt == ACK_SLOT);                             // R5

endmodule

// File: rtl/i2c_ws_ctrl.sv
// Phase control: bus conditions, address compare, ACK drive, SCL hold and interrupt.
// Assumes: synchronized, edge-detected lines; the controller never issues
// START or STOP while this block holds SCL low.
module i2c_ws_ctrl
    import i2c_ws_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1,
    localparam int CNT_W  = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_val,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic              wait_rel,
    output logic              bus_cond,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq,
    output logic              irq_addr,
    output logic              addr_match
);

    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] WRAP     = CNT_W'(DATA_W + 1);

    phase_t phase;
    logic   ack_pend;
    logic   start_c, stop_c, active, addr_hit;

    // Detect START/STOP: SDA edge while SCL was and is high
    assign start_c  = scl_lvl && !scl_rise && sda_fall;
    assign stop_c   = scl_lvl && !scl_rise && sda_rise;
    assign bus_cond = start_c | stop_c;
    assign active   = (phase == PH_ADDR) || (phase == PH_DATA);
    assign addr_hit = (byte_val[DATA_W-1:1] == own_addr) && !byte_val[0];

    // Sequence phases, drive ACK, hold SCL and pulse the interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            ack_pend   <= 1'b0;
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            rx_data    <= '0;
            irq        <= 1'b0;
            irq_addr   <= 1'b0;
            addr_match <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (scl_oe && wait_rel) scl_oe <= 1'b0;
            if (start_c) begin
                phase    <= PH_ADDR;
                sda_oe   <= 1'b0;
                ack_pend <= 1'b0;
            end else if (stop_c) begin
                phase      <= PH_IDLE;
                sda_oe     <= 1'b0;
                ack_pend   <= 1'b0;
                addr_match <= 1'b0;
            end else begin
                if (byte_done && phase == PH_ADDR) begin
                    if (addr_hit) begin
                        addr_match <= 1'b1;
                        ack_pend   <= 1'b1;
                    end else begin
                        addr_match <= 1'b0;
                        phase      <= PH_SKIP;
                    end
                end
                if (byte_done && phase == PH_DATA) begin
                    rx_data  <= byte_val;
                    ack_pend <= ack_en;
                end
                if (scl_fall && cnt == ACK_SLOT && active)
                    sda_oe <= ack_pend;
                if (scl_fall && cnt == WRAP && active) begin
                    sda_oe   <= 1'b0;
                    scl_oe   <= 1'b1;
                    irq      <= 1'b1;
                    irq_addr <= (phase == PH_ADDR);
                    phase    <= PH_DATA;
                end
            end
        end
    end

    AST_HOLD_UNTIL_REL: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && !wait_rel |=> scl_oe);                                    // R4
    AST_REL_DROPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && wait_rel |=> !scl_oe);                                    // R4
    AST_HOLD_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> irq);                                             // R3
    AST_IRQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> addr_match);                                                // R7
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SKIP |-> !sda_oe && !scl_oe && !irq);                   // R8
    AST_SDA_IN_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (cnt == ACK_SLOT || cnt == WRAP));                       // R2

endmodule

// File: rtl/i2c_wait_slave.sv
// Top: I2C slave receiver that acknowledges its own address, holds SCL low
// after every ninth clock of an addressed transfer and waits for a release.
// Assumes: scl_oe/sda_oe drive open-drain pads; inputs are the line levels.
module i2c_wait_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic              wait_rel,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq,
    output logic              irq_addr,
    output logic              addr_match
);

    localparam int CNT_W  = $clog2(DATA_W + 2);
    localparam int N_LINE = 2;   // index 0 = SCL, 1 = SDA

    logic [N_LINE-1:0] raw, lvl, rise, fall;
    logic [CNT_W-1:0]  cnt;
    logic              byte_done, bus_cond;
    logic [DATA_W-1:0] byte_val;

    assign raw = {sda_i, scl_i};

    // One synchronizer per bus line
    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        i2c_ws_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (lvl[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
    end

    i2c_ws_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bus_cond),
        .scl_rise (rise[0]),
        .scl_fall (fall[0]),
        .sda      (lvl[1]),
        .cnt      (cnt),
        .byte_done(byte_done),
        .byte_val (byte_val)
    );

    i2c_ws_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (lvl[0]),
        .scl_rise  (rise[0]),
        .scl_fall  (fall[0]),
        .sda_rise  (rise[1]),
        .sda_fall  (fall[1]),
        .cnt       (cnt),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .own_addr  (own_addr),
        .ack_en    (ack_en),
        .wait_rel  (wait_rel),
        .bus_cond  (bus_cond),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_data   (rx_data),
        .irq       (irq),
        .irq_addr  (irq_addr),
        .addr_match(addr_match)
    );

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                      // R3

endmodule

// File: tb/i2c_wait_slave_tb.sv
// Bench: drives an I2C controller model over wired-AND lines, sweeps all
// addresses, a set of data bytes and the hold/release sequence.
module i2c_wait_slave_tb_top;

    localparam int HALF = 8;
    localparam logic [6:0] OWN = 7'h2D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic [6:0] own_addr = OWN;
    logic       ack_en = 1'b1, wait_rel = 1'b0;
    logic       scl_oe, sda_oe, irq, irq_addr, addr_match;
    logic [7:0] rx_data;
    logic       scl_line, sda_line;

    int checks = 0, failures = 0;
    int irq_cnt = 0, irq_cyc = 0;
    logic oe_at2, oe_at3;
    bit done = 0;

    always #5 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_wait_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .own_addr(own_addr), .ack_en(ack_en), .wait_rel(wait_rel),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
        .irq(irq), .irq_addr(irq_addr), .addr_match(addr_match)
    );

    // Count interrupt pulses and interrupt-high cycles
    logic irq_q = 1'b0;
    always @(posedge clk) begin
        if (irq) irq_cyc++;
        if (irq && !irq_q) irq_cnt++;
        irq_q <= irq;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        cyc(2);
        m_sda_low = !b;
        cyc(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        cyc(HALF);
        m_scl_low = 1'b1;
    endtask

    task automatic ack_bit(output bit ack);
        cyc(2);
        m_sda_low = 1'b0;
        cyc(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        cyc(HALF / 2);
        ack = !sda_line;
        cyc(HALF / 2);
        m_scl_low = 1'b1;
        cyc(2); oe_at2 = scl_oe;
        cyc(1); oe_at3 = scl_oe;
        cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_bit(ack);
    endtask

    task automatic do_start();
        cyc(2);
        m_sda_low = 1'b0;
        cyc(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        cyc(HALF);
        m_sda_low = 1'b1;
        cyc(HALF);
        m_scl_low = 1'b1;
    endtask

    task automatic do_stop();
        cyc(2);
        m_sda_low = 1'b1;
        cyc(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        cyc(HALF);
        m_sda_low = 1'b0;
        cyc(HALF);
    endtask

    task automatic release_hold(input string tag);
        wait_rel = 1'b1;
        cyc(1);
        wait_rel = 1'b0;
        check(scl_oe == 1'b0, tag, scl_oe, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        bit ack;
        int prev;
        logic [7:0] val, last_rx;

        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // Reset state
        check(!scl_oe && !sda_oe && !irq && !addr_match && rx_data == 8'h00,
              "reset", {scl_oe, sda_oe, irq, addr_match}, 0);

        // R2 R3 R8: sweep every address against OWN
        for (int a = 0; a < 128; a++) begin
            bit hit;
            hit = (a == OWN);
            prev = irq_cnt;
            do_start();
            send_byte({a[6:0], 1'b0}, ack);
            check(ack == hit, hit ? "R2 ack on match" : "R8 nack on mismatch", ack, hit);
            check(scl_oe == hit, hit ? "R3 hold on match" : "R8 no hold", scl_oe, hit);
            check(irq_cnt == prev + int'(hit), hit ? "R3 irq" : "R8 no irq", irq_cnt - prev, hit);
            if (hit) begin
                check(oe_at2 == 1'b0 && oe_at3 == 1'b1, "R1 hold latency",
                      {oe_at2, oe_at3}, 2'b01);
                check(irq_addr && addr_match, "R3 irq_addr/addr_match",
                      {irq_addr, addr_match}, 2'b11);
                release_hold("R4 release after address");
            end else if (a % 16 == 0) begin
                last_rx = rx_data;
                prev = irq_cnt;
                send_byte(8'hC3, ack);
                check(!ack && !scl_oe && irq_cnt == prev && rx_data == last_rx,
                      "R8 bytes ignored after mismatch", {ack, scl_oe, rx_data}, {2'b00, last_rx});
            end
            do_stop();
            check(addr_match == 1'b0, "R9 stop clears addr_match", addr_match, 0);
        end

        // R8: own address with the read direction bit
        prev = irq_cnt;
        do_start();
        send_byte({OWN, 1'b1}, ack);
        check(!ack && !scl_oe && irq_cnt == prev, "R8 read request ignored",
              {ack, scl_oe}, 0);
        do_stop();

        // R2: own address values at the range edges
        for (int o = 0; o < 4; o++) begin
            logic [6:0] ov;
            ov = (o == 0) ? 7'h00 : (o == 1) ? 7'h7F : (o == 2) ? 7'h55 : 7'h2A;
            own_addr = ov;
            do_start();
            send_byte({ov, 1'b0}, ack);
            check(ack && scl_oe, "R2 match for own_addr edge value", {ack, scl_oe}, 2'b11);
            release_hold("R4 release");
            do_stop();
        end
        own_addr = OWN;

        // R5 R6 R7 R4: data bytes with ack_en alternating
        do_start();
        send_byte({OWN, 1'b0}, ack);
        release_hold("R4 release after address");
        for (int k = 0; k < 16; k++) begin
            val = 8'((k * 37 + 11) ^ (k << 4));
            ack_en = k[0];
            prev = irq_cnt;
            send_byte(val, ack);
            check(ack == k[0], "R6 data ack follows ack_en", ack, k[0]);
            check(rx_data == val, "R5 rx_data", rx_data, val);
            check(scl_oe && irq_cnt == prev + 1 && !irq_addr, "R7 hold and irq after data",
                  {scl_oe, irq_addr, 8'(irq_cnt - prev)}, {2'b10, 8'd1});
            if (k == 5) begin
                cyc(60);
                check(scl_oe && !scl_line, "R4 hold persists without release", scl_oe, 1);
            end
            release_hold("R4 release after data");
        end
        do_stop();
        ack_en = 1'b1;

        // R9: mismatch then repeated START with own address
        do_start();
        send_byte({7'h11, 1'b0}, ack);
        check(!ack, "R9 first address mismatched", ack, 0);
        do_start();
        send_byte({OWN, 1'b0}, ack);
        check(ack && addr_match && scl_oe, "R9 repeated start readdresses",
              {ack, addr_match, scl_oe}, 3'b111);
        release_hold("R4 release");
        do_stop();

        // R3: every interrupt lasted exactly one cycle
        check(irq_cyc == irq_cnt, "R3 irq single cycle", irq_cyc, irq_cnt);

        done = 1;
        finish_run();
    end

endmodule